// File: doc/BRIEF.md
# Conversion Completion Flags and Result Store

This block sits between a multi-step converter and a CPU register bus. The converter side gives a one-cycle done pulse with a 10-bit data word for each conversion of a sequence. The block keeps a position counter. It writes each word into the result slot for its place in the sequence and raises that slot's completion flag. The counter stops once the programmed sequence length has been reached.

The CPU writes a control address to start a sequence and set its length. It reads the flags through two 8-bit status registers and reads the results through sixteen result registers. The clearing policy depends on a mode input. With fast clear off, a flag drops only when the CPU has read the status register that holds it and then reads the matching result. With fast clear on, reading the result alone drops the flag. When a flag is set and cleared in the same cycle, a start clear wins over the set, and the set wins over a read-based clear.

Reads take effect at the clock edge that ends the read cycle. Read data is a combinational function of the address, so the CPU sees the value from before that edge.

Top module: `cc_flag_bank`

## Requirements
- R1: While a sequence is active, the done pulse for conversion k (counting from 0) stores `cvt_data_i` in result slot k and sets flag k at the next clock edge. The position then advances by one.
- R2: A read at address 16+k returns result k in bits [9:0], and bits [15:10] read as zero.
- R3: A write to address 0 starts a new sequence. It clears every flag and every arming mark, returns the position to 0, and sets the sequence length to `bus_wdata_i[3:0]`+1.
- R4: A done pulse is ignored, leaving flags and results unchanged, in two cases: when the programmed number of conversions has already completed, and when no sequence has been started since reset.
- R5: With `fast_clr_i`=0, a read of result k clears flag k only if the status register holding flag k was read after flag k was set. A result read without that earlier status read leaves the flag set.
- R6: A status read arms only the flags that are set at that moment, and only those in the register read. Address 2 returns flags 7..0 in bits 7..0. Address 3 returns flags 15..8 in bits 7..0. Bits 15..8 of both read as zero.
- R7: With `fast_clr_i`=1, a read of result k clears flag k with no status read needed.
- R8: When a start write and a done pulse fall in the same cycle, all flags are zero afterwards and that done pulse is discarded.
- R9: When a flag set and a read-based clear of the same flag fall in the same cycle, the flag ends up set.
- R10: Status registers are read-only, and writes to them change nothing. After reset all flags and results are zero. Reads of address 0 and of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_clr_i | input | 1 | 1: result read alone clears its flag |
| cvt_done_i | input | 1 | One-cycle conversion done pulse |
| cvt_data_i | input | 10 | Conversion data word |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 5 | Register address |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Register read data (combinational) |

## Verification
The bench builds the block with its default parameters: sixteen slots, 10-bit results and a 5-bit address. At this size every sequence length from 1 to 16 can be swept under both clearing modes. Each sweep runs two extra done pulses past the end of the sequence, which tests the stop condition at every length. A reference model kept in the bench follows each clearing, arming and collision rule, and every read is compared against it. Targeted cases add the two collision orders, arming limited to one status register, and writes aimed at the read-only registers.

// File: rtl/cc_bank_pkg.sv
package cc_bank_pkg;

  localparam int GRP_W     = 8;
  localparam int CTRL_ADDR = 0;
  localparam int STAT_BASE = 2;
  localparam int RES_BASE  = 16;

  function automatic int num_groups(input int n_slots);
    return (n_slots + GRP_W - 1) / GRP_W;
  endfunction

  function automatic logic in_window(input int a, input int base, input int n);
    return (a >= base) && (a < base + n);
  endfunction

  function automatic logic is_last_pos(input int pos, input int last);
    return pos == last;
  endfunction

endpackage

// File: rtl/cc_seq_ctrl.sv
module cc_seq_ctrl #(
  parameter int NUM_SLOTS = 16,
  localparam int POS_W = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [POS_W-1:0] len_m1_i,
  input  logic             done_i,
  output logic             set_en_o,
  output logic [POS_W-1:0] set_pos_o
);
  import cc_bank_pkg::*;

  logic             active_q;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] last_q;
  logic             at_last;

  assign at_last   = is_last_pos(32'(pos_q), 32'(last_q));
  assign set_en_o  = done_i && active_q && !start_i;
  assign set_pos_o = pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pos_q    <= '0;
      last_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      pos_q    <= '0;
      last_q   <= len_m1_i;
    end else if (set_en_o) begin
      if (at_last) active_q <= 1'b0;
      else         pos_q    <= pos_q + 1'b1;
    end
  end

  AST_POS_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> pos_q <= last_q); // R4
  AST_STOP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en_o && at_last) |=> !active_q); // R4
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (active_q && pos_q == '0)); // R3

endmodule

// File: rtl/cc_flag_ctrl.sv
module cc_flag_ctrl #(
  parameter int NUM_SLOTS = 16,
  localparam int POS_W = $clog2(NUM_SLOTS),
  localparam int NUM_GRP = cc_bank_pkg::num_groups(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 fast_clr_i,
  input  logic                 set_en_i,
  input  logic [POS_W-1:0]     set_pos_i,
  input  logic [NUM_GRP-1:0]   stat_rd_i,
  input  logic                 res_rd_i,
  input  logic [POS_W-1:0]     res_slot_i,
  output logic [NUM_SLOTS-1:0] flags_o
);
  import cc_bank_pkg::*;

  logic [NUM_SLOTS-1:0] flags_q, arm_q;
  logic [NUM_SLOTS-1:0] set_vec, clr_req, stat_arm;
  logic [NUM_SLOTS-1:0] flags_n, arm_n;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign set_vec[i]  = set_en_i && (set_pos_i == POS_W'(i));
    assign clr_req[i]  = res_rd_i && (res_slot_i == POS_W'(i)) && (fast_clr_i || arm_q[i]);
    assign stat_arm[i] = stat_rd_i[i / GRP_W] && flags_q[i];
  end

  always_comb begin
    if (start_i) begin
      flags_n = '0;
      arm_n   = '0;
    end else begin
      flags_n = (flags_q & ~clr_req) | set_vec;
      arm_n   = (arm_q | stat_arm) & flags_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      arm_q   <= '0;
    end else begin
      flags_q <= flags_n;
      arm_q   <= arm_n;
    end
  end

  assign flags_o = flags_q;

  AST_START_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> flags_q == '0); // R3
  AST_ARM_WITHIN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q & ~flags_q) == '0); // R6
  AST_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (flags_q & ~$past(flags_q) & ~$past(set_vec)) == '0); // R1
  AST_SET_WINS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & clr_req) != '0 && !start_i) |=>
      (flags_q & $past(set_vec & clr_req)) == $past(set_vec & clr_req)); // R9
  AST_SLOW_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !fast_clr_i) |=> ($past(flags_q) & ~flags_q & ~$past(arm_q)) == '0); // R5

endmodule

// File: rtl/cc_result_bank.sv
module cc_result_bank #(
  parameter int NUM_SLOTS = 16,
  parameter int RES_W = 10,
  localparam int POS_W = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [POS_W-1:0] wr_slot_i,
  input  logic [RES_W-1:0] wr_data_i,
  input  logic [POS_W-1:0] rd_slot_i,
  output logic [RES_W-1:0] rd_data_o
);

  logic [RES_W-1:0] res_q [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_res
    always_ff @(posedge clk) begin
      if (!rst_n)
        res_q[i] <= '0;
      else if (wr_en_i && wr_slot_i == POS_W'(i))
        res_q[i] <= wr_data_i;
    end
  end

  assign rd_data_o = res_q[rd_slot_i];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> res_q[$past(wr_slot_i)] == $past(wr_data_i)); // R1

endmodule

// File: rtl/cc_flag_bank.sv
module cc_flag_bank #(
  parameter int NUM_SLOTS = 16,
  parameter int RES_W = 10,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  localparam int POS_W = $clog2(NUM_SLOTS),
  localparam int NUM_GRP = cc_bank_pkg::num_groups(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_clr_i,
  input  logic              cvt_done_i,
  input  logic [RES_W-1:0]  cvt_data_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o
);
  import cc_bank_pkg::*;

  logic                       seq_start;
  logic                       set_en;
  logic [POS_W-1:0]           set_pos;
  logic [NUM_GRP-1:0]         stat_hit, stat_rd;
  logic                       res_hit, res_rd;
  logic [ADDR_W-1:0]          res_off;
  logic [POS_W-1:0]           res_slot;
  logic [NUM_SLOTS-1:0]       flags;
  logic [NUM_GRP*GRP_W-1:0]   flags_pad;
  logic [RES_W-1:0]           res_word;
  logic                       unused_wdata_bits;
  logic                       unused_off_bits;

  assign seq_start = bus_wr_i && (bus_addr_i == ADDR_W'(CTRL_ADDR));
  assign res_hit   = in_window(32'(bus_addr_i), RES_BASE, NUM_SLOTS);
  assign res_rd    = bus_rd_i && res_hit;
  assign res_off   = bus_addr_i - ADDR_W'(RES_BASE);
  assign res_slot  = res_off[POS_W-1:0];

  assign unused_wdata_bits = ^bus_wdata_i[DATA_W-1:POS_W];
  assign unused_off_bits   = ^res_off[ADDR_W-1:POS_W];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_stat
    assign stat_hit[g] = (bus_addr_i == ADDR_W'(STAT_BASE + g));
    assign stat_rd[g]  = bus_rd_i && stat_hit[g];
  end

  cc_seq_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (seq_start),
    .len_m1_i  (bus_wdata_i[POS_W-1:0]),
    .done_i    (cvt_done_i),
    .set_en_o  (set_en),
    .set_pos_o (set_pos)
  );

  cc_flag_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (seq_start),
    .fast_clr_i (fast_clr_i),
    .set_en_i   (set_en),
    .set_pos_i  (set_pos),
    .stat_rd_i  (stat_rd),
    .res_rd_i   (res_rd),
    .res_slot_i (res_slot),
    .flags_o    (flags)
  );

  cc_result_bank #(.NUM_SLOTS(NUM_SLOTS), .RES_W(RES_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (set_en),
    .wr_slot_i (set_pos),
    .wr_data_i (cvt_data_i),
    .rd_slot_i (res_slot),
    .rd_data_o (res_word)
  );

  assign flags_pad = (NUM_GRP*GRP_W)'(flags);

  always_comb begin
    bus_rdata_o = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (stat_hit[g]) bus_rdata_o = DATA_W'(flags_pad[g*GRP_W +: GRP_W]);
    end
    if (res_hit) bus_rdata_o = DATA_W'(res_word);
  end

  AST_RES_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && res_hit) |-> bus_rdata_o[DATA_W-1:RES_W] == '0); // R2
  AST_START_BEATS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_start && cvt_done_i) |=> flags == '0); // R8

endmodule

// File: tb/test_cc_flag_bank.sv
module test_cc_flag_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fast_clr = 1'b0;
  logic        cvt_done = 1'b0;
  logic [9:0]  cvt_data = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  always #5 clk = ~clk;

  cc_flag_bank i_cc_flag_bank (
    .clk(clk), .rst_n(rst_n), .fast_clr_i(fast_clr),
    .cvt_done_i(cvt_done), .cvt_data_i(cvt_data),
    .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata)
  );

  int  n_chk = 0;
  int  n_fail = 0;
  bit  ended = 1'b0;

  // reference state built from the requirements
  logic [15:0] m_flags = '0;
  logic [15:0] m_arm = '0;
  logic [9:0]  m_res [16];
  int          m_pos = 0;
  int          m_len = 1;
  bit          m_act = 1'b0;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_read(input logic [4:0] a);
    if (a == 5'd2) return {8'h00, m_flags[7:0]};
    if (a == 5'd3) return {8'h00, m_flags[15:8]};
    if (a >= 5'd16) return {6'b0, m_res[a - 5'd16]};
    return 16'h0000;
  endfunction

  task automatic m_step(input bit wr, input bit rd, input logic [4:0] a,
                        input logic [15:0] wd, input bit dn, input logic [9:0] dd);
    bit          start;
    logic [15:0] setv, clrv, armv, nf;
    start = wr && (a == 5'd0);
    setv = '0; clrv = '0; armv = '0;
    if (!start && dn && m_act) setv[m_pos] = 1'b1;
    if (rd && a >= 5'd16 && (fast_clr || m_arm[a - 5'd16])) clrv[a - 5'd16] = 1'b1;
    if (rd && a == 5'd2) armv[7:0]  = m_flags[7:0];
    if (rd && a == 5'd3) armv[15:8] = m_flags[15:8];
    if (start) begin
      m_flags = '0; m_arm = '0; m_pos = 0; m_act = 1'b1;
      m_len = int'(wd[3:0]) + 1;
    end else begin
      nf = (m_flags & ~clrv) | setv;
      m_arm = (m_arm | armv) & nf;
      m_flags = nf;
      if (setv != 0) begin
        m_res[m_pos] = dd;
        if (m_pos == m_len - 1) m_act = 1'b0;
        else m_pos++;
      end
    end
  endtask

  // one bus/converter cycle, starting and ending at a falling edge
  task automatic cyc(input bit wr, input bit rd, input logic [4:0] a, input logic [15:0] wd,
                     input bit dn, input logic [9:0] dd, input string tag,
                     output logic [15:0] got);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    cvt_done = dn; cvt_data = dd;
    #1;
    got = bus_rdata;
    if (rd) check(tag, got, m_read(a));
    m_step(wr, rd, a, wd, dn, dd);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; cvt_done = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, input string tag, output logic [15:0] got);
    cyc(1'b0, 1'b1, a, 16'h0, 1'b0, 10'h0, tag, got);
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
    logic [15:0] g;
    cyc(1'b1, 1'b0, a, d, 1'b0, 10'h0, "", g);
  endtask

  task automatic pulse(input logic [9:0] d);
    logic [15:0] g;
    cyc(1'b0, 1'b0, 5'd0, 16'h0, 1'b1, d, "", g);
  endtask

  function automatic logic [9:0] pat(input int len, input int k, input int fm);
    return 10'((len * 37 + k * 53 + fm * 301 + (k % 2) * 512) % 1024);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] g;
    logic [15:0] mask;
    for (int i = 0; i < 16; i++) m_res[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset values and unmapped reads
    rd_reg(5'd2, "R10", g);  check("R10", g, 16'h0000);
    rd_reg(5'd3, "R10", g);  check("R10", g, 16'h0000);
    rd_reg(5'd16, "R10", g); check("R10", g, 16'h0000);
    rd_reg(5'd31, "R10", g); check("R10", g, 16'h0000);
    rd_reg(5'd0, "R10", g);  check("R10", g, 16'h0000);
    rd_reg(5'd7, "R10", g);  check("R10", g, 16'h0000);

    // R4: done pulse before any start is ignored
    pulse(10'h2AA);
    rd_reg(5'd2, "R4", g);  check("R4", g, 16'h0000);
    rd_reg(5'd16, "R4", g); check("R4", g, 16'h0000);

    // R10: writes to status registers do nothing
    wr_reg(5'd2, 16'h00FF);
    rd_reg(5'd2, "R10", g); check("R10", g, 16'h0000);

    // sweep: both clear modes, every length
    for (int fm = 0; fm < 2; fm++) begin
      fast_clr = fm[0];
      for (int len = 1; len <= 16; len++) begin
        wr_reg(5'd0, 16'(len - 1));
        rd_reg(5'd2, "R3", g); check("R3", g, 16'h0000);
        rd_reg(5'd3, "R3", g); check("R3", g, 16'h0000);
        for (int k = 0; k < len + 2; k++) pulse(pat(len, k, fm));
        mask = 16'((32'h1 << len) - 1);
        rd_reg(5'd16, "R2", g); check("R1", g, {6'b0, pat(len, 0, fm)});
        if (fm == 1) mask[0] = 1'b0;
        rd_reg(5'd2, fm ? "R7" : "R5", g); check(fm ? "R7" : "R5", g, {8'h00, mask[7:0]});
        rd_reg(5'd3, "R4", g); check("R4", g, {8'h00, mask[15:8]});
        for (int k = 0; k < len; k++) begin
          rd_reg(5'(16 + k), "R2", g); check("R1", g, {6'b0, pat(len, k, fm)});
        end
        rd_reg(5'd2, fm ? "R7" : "R5", g); check(fm ? "R7" : "R5", g, 16'h0000);
        rd_reg(5'd3, fm ? "R7" : "R5", g); check(fm ? "R7" : "R5", g, 16'h0000);
      end
    end

    // R6: arming covers only flags set at the status read
    fast_clr = 1'b0;
    wr_reg(5'd0, 16'd3);
    pulse(10'h101); pulse(10'h102);
    rd_reg(5'd2, "R6", g); check("R6", g, 16'h0003);
    pulse(10'h103); pulse(10'h104);
    rd_reg(5'd18, "R6", g);
    rd_reg(5'd19, "R6", g);
    rd_reg(5'd2, "R6", g); check("R6", g, 16'h000F);
    rd_reg(5'd17, "R5", g); check("R5", g, 16'h0102);
    rd_reg(5'd2, "R6", g); check("R6", g, 16'h000D);

    // R6: arming is limited to the register read
    wr_reg(5'd0, 16'd15);
    for (int k = 0; k < 16; k++) pulse(10'(k + 16));
    rd_reg(5'd3, "R6", g); check("R6", g, 16'h00FF);
    rd_reg(5'd16, "R6", g);
    rd_reg(5'd24, "R6", g);
    rd_reg(5'd2, "R6", g); check("R6", g, 16'h00FF);
    rd_reg(5'd3, "R6", g); check("R6", g, 16'h00FE);

    // R10: write to a status register leaves flags alone
    wr_reg(5'd3, 16'h0000);
    rd_reg(5'd3, "R10", g); check("R10", g, 16'h00FE);

    // R8: start and done in the same cycle
    cyc(1'b1, 1'b0, 5'd0, 16'd1, 1'b1, 10'h3FF, "", g);
    rd_reg(5'd2, "R8", g); check("R8", g, 16'h0000);
    rd_reg(5'd3, "R8", g); check("R8", g, 16'h0000);
    pulse(10'h155);
    rd_reg(5'd2, "R8", g);  check("R8", g, 16'h0001);
    rd_reg(5'd16, "R8", g); check("R8", g, 16'h0155);

    // R9: read-based clear and set on the same flag in one cycle
    fast_clr = 1'b1;
    wr_reg(5'd0, 16'd1);
    cyc(1'b0, 1'b1, 5'd16, 16'h0, 1'b1, 10'h2C3, "R9", g);
    rd_reg(5'd2, "R9", g); check("R9", g, 16'h0001);
    rd_reg(5'd16, "R7", g); check("R7", g, 16'h02C3);
    rd_reg(5'd2, "R7", g); check("R7", g, 16'h0000);

    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule